// File: doc/BRIEF.md
# Gated Binary Clock Divider

The block takes one input clock and derives a set of divided clocks from it, by default three taps at one half, one quarter and one eighth of the input rate. Each tap is presented as a true output and a complementary output that is always its exact inverse. All taps come from a single down counter. They are phase aligned and rise together whenever the counter leaves its idle state.

An active-low run request (`run_n_i`) starts and stops the taps. The request is captured on a rising input edge before it acts, so any change is aligned to the input clock. A stop request does not cut the outputs off. The counter coasts to the end of its current cycle, and the taps come to rest with every true output low and every inverted output high, so no high or low phase is ever shortened. A later start request restarts the counter from that rest state, and all taps rise together. An active-high reset clears the counter and the captured request on the next rising edge, which forces the same rest polarity.

Top module: `gated_clk_div`

## Requirements
- R1: While counting, `div_o[0]` toggles on every input rising edge, giving a period of 2 input cycles.
- R2: While counting, `div_o[1]` has a period of 4 input cycles and changes only on edges where `div_o[0]` was low.
- R3: While counting, `div_o[2]` has a period of 8 input cycles and changes only on edges where `div_o[1:0]` was 2'b00.
- R4: Every tap has a 50% duty cycle: tap j stays high for exactly 2^j input cycles and stays low for 2^j cycles while counting.
- R5: `div_n_o[j]` is the logical inverse of `div_o[j]` in every cycle, including during reset and hold.
- R6: When `rst_i` is high at a rising edge, after that edge every true output is 0 and every inverted output is 1, whatever the value of `run_n_i`.
- R7: When `run_n_i` is sampled high, the taps finish their current 8-cycle frame and then rest with all true outputs 0. They stay there for as long as `run_n_i` is sampled high.
- R8: When the taps are at rest and `run_n_i` is sampled low at a rising edge, all true outputs rise together on the next rising edge. The same holds for the first start after reset.
- R9: Across any sequence of run and stop requests, no completed high phase of tap j differs from 2^j cycles, and no completed low phase is shorter than 2^j cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Active-high reset, sampled on the rising edge |
| run_n_i | input | 1 | Active-low run request, captured on the rising edge |
| div_o | output | NUM_TAPS (3) | True divided clocks; bit j runs at input rate / 2^(j+1) |
| div_n_o | output | NUM_TAPS (3) | Inverted divided clocks |

## Verification
A run request sampled at rising edge k takes effect at the counter on edge k+1, so the taps rise in the cycle after edge k+1. A reset sampled at edge k clears the outputs right after edge k. The bench drives every input just after a falling edge and samples on the falling edge. For a start issued after sample n, it therefore expects the rest value at sample n+1 and all taps high at sample n+2. For a reset issued before a sample, it expects the rest value at the next sample. Pulse widths are measured on a recorded trace of one sample per input cycle, and only phases with both ends inside the trace are judged.

// File: rtl/gdiv_pkg.sv
package gdiv_pkg;

    // Default number of divided taps; tap j divides by 2^(j+1).
    localparam int unsigned DEF_TAPS = 3;

    // Phase of the shared divider counter.
    typedef enum logic [1:0] {
        PH_REST  = 2'd0,   // counter at zero, no run request
        PH_COUNT = 2'd1,   // counter stepping under a run request
        PH_COAST = 2'd2    // run withdrawn, finishing the current frame
    } div_phase_e;

    // Decoded step control handed from the counter control to the counter.
    typedef struct packed {
        logic step;        // decrement this edge
        logic clear;       // force counter to zero this edge
    } step_ctl_t;

    // True when the counter value is the rest value (all taps low).
    function automatic logic at_rest(input logic [31:0] value, input int unsigned width);
        logic r;
        r = 1'b1;
        for (int unsigned i = 0; i < 32; i++) begin
            if (i < width && value[i]) begin
                r = 1'b0;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/gdiv_run_capture.sv
module gdiv_run_capture (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_n_i,
    output logic run_q_o
);

    // The request is registered before it steers the counter, so the counter
    // reacts one edge after the request is sampled.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q_o <= 1'b0;
        end else begin
            run_q_o <= ~run_n_i;
        end
    end

endmodule

// File: rtl/gdiv_step_ctl.sv
module gdiv_step_ctl
    import gdiv_pkg::*;
#(
    parameter int unsigned NUM_TAPS = DEF_TAPS
) (
    input  logic                rst_i,
    input  logic                run_q_i,
    input  logic [NUM_TAPS-1:0] count_i,
    output step_ctl_t           ctl_o,
    output div_phase_e          phase_o
);

    localparam int unsigned CW = NUM_TAPS;

    logic idle;

    always_comb begin
        idle = at_rest(32'(count_i), CW);
    end

    // Phase decode: counting under request, coasting to the frame end, or resting.
    always_comb begin
        if (run_q_i) begin
            phase_o = PH_COUNT;
        end else if (!idle) begin
            phase_o = PH_COAST;
        end else begin
            phase_o = PH_REST;
        end
    end

    always_comb begin
        ctl_o.clear = rst_i;
        ctl_o.step  = 1'b0;
        unique case (phase_o)
            PH_COUNT: ctl_o.step = 1'b1;
            PH_COAST: ctl_o.step = 1'b1;
            default:  ctl_o.step = 1'b0;
        endcase
    end

endmodule

// File: rtl/gdiv_counter.sv
module gdiv_counter
    import gdiv_pkg::*;
#(
    parameter int unsigned NUM_TAPS = DEF_TAPS
) (
    input  logic                clk_i,
    input  step_ctl_t           ctl_i,
    output logic [NUM_TAPS-1:0] count_o
);

    localparam int unsigned CW = NUM_TAPS;
    localparam logic [CW-1:0] ONE = CW'(1);

    // Down counter: leaving zero sets every bit at once, so all taps rise
    // together; bit j toggles every 2^j steps.
    always_ff @(posedge clk_i) begin
        if (ctl_i.clear) begin
            count_o <= '0;
        end else if (ctl_i.step) begin
            count_o <= count_o - ONE;
        end
    end

endmodule

// File: rtl/gdiv_tap_pair.sv
module gdiv_tap_pair (
    input  logic bit_i,
    output logic true_o,
    output logic inv_o
);

    assign true_o = bit_i;
    assign inv_o  = ~bit_i;

endmodule

// File: rtl/gated_clk_div.sv
module gated_clk_div
    import gdiv_pkg::*;
#(
    parameter int unsigned NUM_TAPS = DEF_TAPS
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                run_n_i,
    output logic [NUM_TAPS-1:0] div_o,
    output logic [NUM_TAPS-1:0] div_n_o
);

    logic                run_q;
    logic [NUM_TAPS-1:0] count;
    step_ctl_t           ctl;
    div_phase_e          phase;

    gdiv_run_capture u_cap (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .run_n_i (run_n_i),
        .run_q_o (run_q)
    );

    gdiv_step_ctl #(.NUM_TAPS(NUM_TAPS)) u_ctl (
        .rst_i   (rst_i),
        .run_q_i (run_q),
        .count_i (count),
        .ctl_o   (ctl),
        .phase_o (phase)
    );

    gdiv_counter #(.NUM_TAPS(NUM_TAPS)) u_cnt (
        .clk_i   (clk_i),
        .ctl_i   (ctl),
        .count_o (count)
    );

    for (genvar j = 0; j < NUM_TAPS; j++) begin : g_tap
        gdiv_tap_pair u_pair (
            .bit_i  (count[j]),
            .true_o (div_o[j]),
            .inv_o  (div_n_o[j])
        );
    end

    // The phase is only needed for decode inside the controller.
    logic phase_unused;
    assign phase_unused = ^phase;

endmodule

// File: rtl/gdiv_checker.sv
module gdiv_checker #(
    parameter int unsigned NUM_TAPS = 3
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                run_n_i,
    input logic [NUM_TAPS-1:0] div_o,
    input logic [NUM_TAPS-1:0] div_n_o
);

    // R6: a sampled reset leaves the rest polarity on both output sets.
    a_r6_reset_rest: assert property (@(posedge clk_i)
        rst_i |=> (div_o == '0 && div_n_o == '1));

    // R1: tap 0 toggles on every edge while the counter is away from rest.
    a_r1_tap0_toggles: assert property (@(posedge clk_i) disable iff (rst_i)
        (div_o != '0) |=> (div_o[0] != $past(div_o[0])));

    // R2, R3: an upper tap holds unless all lower taps were low.
    for (genvar j = 1; j < NUM_TAPS; j++) begin : g_borrow
        a_r3_upper_tap_holds: assert property (@(posedge clk_i) disable iff (rst_i)
            (div_o[j-1:0] != '0) |=> $stable(div_o[j]));
    end

    // R7: at rest with a stop request captured, the taps stay at rest.
    a_r7_hold_stays: assert property (@(posedge clk_i) disable iff (rst_i)
        (div_o == '0 && $past(run_n_i)) |=> (div_o == '0));

    // R8: at rest with a run request captured, all taps rise together.
    a_r8_start_aligned: assert property (@(posedge clk_i) disable iff (rst_i)
        (div_o == '0 && !$past(run_n_i) && !$past(rst_i)) |=> (div_o == '1));

    // R5: complementary outputs agree at each edge.
    a_r5_complement: assert property (@(posedge clk_i)
        (div_n_o == ~div_o));

endmodule

bind gated_clk_div gdiv_checker #(.NUM_TAPS(NUM_TAPS)) u_gdiv_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .run_n_i (run_n_i),
    .div_o   (div_o),
    .div_n_o (div_n_o)
);

// File: tb/tb_gated_clk_div.sv
module tb_gated_clk_div;

    localparam int NT = 3;
    localparam int TRACE = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run_n = 1'b0;
    logic [NT-1:0] div;
    logic [NT-1:0] div_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [NT-1:0] trace [TRACE];

    gated_clk_div #(.NUM_TAPS(NT)) dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .run_n_i (run_n),
        .div_o   (div),
        .div_n_o (div_n)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // R6: reset forces rest polarity regardless of the run request.
    task automatic t_reset(input logic req_n);
        @(negedge clk);
        rst = 1'b1;
        run_n = req_n;
        @(negedge clk);
        chk(div == '0, "R6 true outputs low in reset", int'(div), 0);
        chk(div_n == '1, "R6 inverted outputs high in reset", int'(div_n), 7);
        chk(div_n == ~div, "R5 complement in reset", int'(div_n), int'(~div));
    endtask

    // R8 R1 R2 R3 R4 R5: start after reset, then check the counting pattern.
    task automatic t_start_and_count();
        rst = 1'b0;
        run_n = 1'b0;
        @(negedge clk);
        chk(div == '0, "R8 still at rest one edge after release", int'(div), 0);
        @(negedge clk);
        chk(div == '1, "R8 all taps rise together after reset", int'(div), 7);
        for (int i = 0; i < 32; i++) begin
            for (int j = 0; j < NT; j++) begin
                logic e;
                e = ((i >> j) & 1) == 0;
                if (j == 0)      chk(div[j] == e, "R1 tap0 pattern", int'(div[j]), int'(e));
                else if (j == 1) chk(div[j] == e, "R2 tap1 pattern", int'(div[j]), int'(e));
                else             chk(div[j] == e, "R3 tap2 pattern", int'(div[j]), int'(e));
            end
            chk(div_n == ~div, "R5 complement while counting", int'(div_n), int'(~div));
            @(negedge clk);
        end
    endtask

    // R4 R9: judge every completed phase in the recorded trace.
    task automatic judge_widths(input string req);
        for (int j = 0; j < NT; j++) begin
            int  len;
            int  runs;
            logic v;
            v = trace[0][j];
            len = 1;
            runs = 0;
            for (int i = 1; i < TRACE; i++) begin
                if (trace[i][j] == v) begin
                    len++;
                end else begin
                    if (runs > 0) begin
                        if (v) chk(len == (1 << j), req, len, 1 << j);
                        else   chk(len >= (1 << j), req, len, 1 << j);
                    end
                    runs++;
                    v = trace[i][j];
                    len = 1;
                end
            end
        end
    endtask

    // R7 R8 R9: stop and start requests at awkward points within a frame.
    task automatic t_gating();
        for (int i = 0; i < TRACE; i++) begin
            trace[i] = div;
            if (i >= 75 && i <= 91)
                chk(div == '0, "R7 taps rest while stopped", int'(div), 0);
            if (i == 92)
                chk(div == '1, "R8 taps rise together on restart", int'(div), 7);
            chk(div_n == ~div, "R5 complement while gating", int'(div_n), int'(~div));
            case (i)
                13: run_n = 1'b1;
                15: run_n = 1'b0;
                40: run_n = 1'b1;
                55: run_n = 1'b0;
                60: run_n = 1'b1;
                90: run_n = 1'b0;
                default: ;
            endcase
            @(negedge clk);
        end
        judge_widths("R9 phase width across gating");
    endtask

    // R4: widths on an ungated stretch.
    task automatic t_duty();
        run_n = 1'b0;
        for (int i = 0; i < TRACE; i++) begin
            trace[i] = div;
            @(negedge clk);
        end
        judge_widths("R4 duty cycle while counting");
    endtask

    // R6: reset mid-frame clears at once.
    task automatic t_reset_midrun();
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(div == '0, "R6 mid-frame reset clears taps", int'(div), 0);
        chk(div_n == '1, "R6 mid-frame reset sets inverted taps", int'(div_n), 7);
    endtask

    initial begin
        t_reset(1'b0);
        t_reset(1'b1);
        t_start_and_count();
        t_gating();
        t_duty();
        t_reset_midrun();
        t_reset(1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule